// File: doc/BRIEF.md
# Shift-Chain Show-Ahead FIFO

A small single-clock FIFO whose storage is a chain of registers that shifts on every accepted write. The newest word always enters at position 0 and each older word moves one place along, so the chain needs no write address at all. An occupancy counter tracks how many words are held, and the oldest word sits at position occupancy minus one, which drives the read data output. Coded this way, the storage has no reset and only a shift enable, so synthesis can place it in shift-register lookup tables.

The read side is show-ahead: the oldest word is already on the read data output while the FIFO is not empty. Pulsing the read input acknowledges that word, and the next word appears after the clock edge. The depth is fixed at 16 entries and the data width is a parameter. A second parameter selects the storage coding: whole-word registers, or one 16-tap shift column per data bit. The column coding exists only for depth 16.

Top module: `shift_fifo`

## Requirements
- R1: After reset is released, empty_o is 1 and full_o is 0.
- R2: A write into an empty FIFO clears empty_o and puts the written word on rd_data_o one clock edge later, with no read needed.
- R3: Words leave in the order they were written. A read acknowledges the word on rd_data_o, and the next older-to-newer word is shown after that edge.
- R4: full_o is 1 exactly when 16 words are held, and empty_o is 1 exactly when none are held. The two are never 1 together.
- R5: A write while full_o is 1 and rd_i is 0 is dropped. The 16 stored words and their order are unchanged.
- R6: A read while empty_o is 1 and wr_i is 0 is ignored. The FIFO stays empty, and the occupancy does not wrap.
- R7: A read and a write in the same cycle, with the FIFO neither empty nor full, keep the occupancy and both flags unchanged and keep the FIFO order.
- R8: When full, a read and a write in the same cycle accept only the read, so full_o falls. When empty, they accept only the write, so empty_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Word to write |
| rd_i | input | 1 | Read acknowledge for the word shown |
| rd_data_o | output | DATA_W | Oldest stored word (show-ahead) |
| empty_o | output | 1 | No words held |
| full_o | output | 1 | 16 words held |

## Verification
Every result is due at the first rising edge after its stimulus. The counter and the chain update on that edge, and the flags and read data follow from them through logic with no registers. The bench drives inputs on the falling edge and compares against a queue model on the next falling edge, so each check falls exactly one edge after its stimulus. The read data is compared only while the model is not empty, because the output holds no defined word when the FIFO is empty.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;
  localparam int unsigned FIFO_DEPTH = 16;
  localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned IDX_W      = $clog2(FIFO_DEPTH);
endpackage

// File: rtl/shift_fifo_chain.sv
module shift_fifo_chain
  import shift_fifo_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter bit          COLUMN_MAP = 1'b0
) (
  input  logic              clk_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] q_o
);
  // No reset on storage: keeps it mappable to shift-register LUTs.
  if (COLUMN_MAP) begin : g_column
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic [FIFO_DEPTH-1:0] col_q;
      always_ff @(posedge clk_i) begin
        if (shift_i) col_q <= {col_q[FIFO_DEPTH-2:0], d_i[b]};
      end
      assign q_o[b] = col_q[idx_i];
    end
  end else begin : g_word
    logic [DATA_W-1:0] mem_q [FIFO_DEPTH];
    always_ff @(posedge clk_i) begin
      if (shift_i) begin
        mem_q[0] <= d_i;
        for (int i = 1; i < FIFO_DEPTH; i++) mem_q[i] <= mem_q[i-1];
      end
    end
    assign q_o = mem_q[idx_i];
  end
endmodule

// File: rtl/shift_fifo_ctrl.sv
module shift_fifo_ctrl
  import shift_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic             shift_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             wr_ok, rd_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(FIFO_DEPTH));
  assign wr_ok   = wr_i & ~full_o;
  assign rd_ok   = rd_i & ~empty_o;
  assign shift_o = wr_ok;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_ok && !rd_ok)      cnt_d = cnt_q + CNT_W'(1);
    else if (rd_ok && !wr_ok) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign last     = cnt_q - CNT_W'(1);
  assign rd_idx_o = last[IDX_W-1:0];
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
  import shift_fifo_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter bit          COLUMN_MAP = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o
);
  logic             shift;
  logic [IDX_W-1:0] rd_idx;

  shift_fifo_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .shift_o  (shift),
    .rd_idx_o (rd_idx),
    .empty_o  (empty_o),
    .full_o   (full_o)
  );

  shift_fifo_chain #(
    .DATA_W     (DATA_W),
    .COLUMN_MAP (COLUMN_MAP)
  ) u_chain (
    .clk_i   (clk_i),
    .shift_i (shift),
    .d_i     (wr_data_i),
    .idx_i   (rd_idx),
    .q_o     (rd_data_o)
  );
endmodule

// File: rtl/shift_fifo_chk.sv
module shift_fifo_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              empty_o,
  input logic              full_o
);
  assert_flags_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));

  assert_show_ahead_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && wr_i |=> !empty_o && rd_data_o == $past(wr_data_i));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_i && !rd_i |=> full_o);

  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_i && !wr_i |=> empty_o);

  assert_hold_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o && !full_o && wr_i && rd_i |=> $stable(empty_o) && $stable(full_o));

  assert_full_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_i && rd_i |=> !full_o);

  assert_full_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o ##1 full_o |-> $past(wr_i) && !$past(rd_i));
endmodule

bind shift_fifo shift_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .wr_data_i (wr_data_i),
  .rd_i      (rd_i),
  .rd_data_o (rd_data_o),
  .empty_o   (empty_o),
  .full_o    (full_o)
);

// File: tb/shift_fifo_tb_top.sv
`timescale 1ns/1ps
module shift_fifo_tb_top;
  localparam int W = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic empty, full;
  logic [W-1:0] model[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shift_fifo #(.DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wdata),
    .rd_i(rd), .rd_data_o(rdata), .empty_o(empty), .full_o(full)
  );

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(empty == (model.size() == 0), req, "empty", empty, model.size() == 0);
    chk(full == (model.size() == DEPTH), req, "full", full, model.size() == DEPTH);
    if (model.size() > 0)
      chk(rdata == model[0], req, "rd_data", rdata, model[0]);
  endtask

  // One cycle: drive at negedge, model updates at posedge, back at negedge.
  task automatic cyc(input bit w, input logic [W-1:0] d, input bit r);
    bit wok, rok;
    wr = w; wdata = d; rd = r;
    wok = w && model.size() < DEPTH;
    rok = r && model.size() > 0;
    @(posedge clk);
    if (rok) void'(model.pop_front());
    if (wok) model.push_back(d);
    @(negedge clk);
    wr = 0; rd = 0;
  endtask

  task automatic t_reset();
    chk(empty == 1'b1, "R1", "empty after reset", empty, 1);
    chk(full == 1'b0, "R1", "full after reset", full, 0);
  endtask

  task automatic t_show_ahead();
    cyc(1, 16'hA5A5, 0);
    chk(rdata == 16'hA5A5, "R2", "shown word", rdata, 16'hA5A5);
    chk(empty == 1'b0, "R2", "empty", empty, 0);
    cyc(0, '0, 1);
    check_state("R2");
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) begin
      cyc(1, W'(16'h1000 + i * 7), 0);
      check_state("R3");
    end
    while (model.size() > 0) begin
      cyc(0, '0, 1);
      check_state("R3");
    end
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1, W'(16'h2000 + i), 0);
      check_state("R4");
    end
    chk(full == 1'b1, "R4", "full at 16", full, 1);
    cyc(1, 16'hDEAD, 0);
    check_state("R5");
    cyc(1, 16'hBEEF, 0);
    check_state("R5");
    for (int i = 0; i < DEPTH; i++) begin
      chk(rdata == W'(16'h2000 + i), "R5", "kept word", rdata, 16'h2000 + i);
      cyc(0, '0, 1);
    end
    check_state("R5");
  endtask

  task automatic t_underflow();
    cyc(0, '0, 1);
    check_state("R6");
    cyc(0, '0, 1);
    check_state("R6");
    cyc(1, 16'h3333, 0);
    check_state("R6");
    cyc(0, '0, 1);
    check_state("R6");
  endtask

  task automatic t_simul();
    for (int i = 0; i < 4; i++) cyc(1, W'(16'h4000 + i), 0);
    for (int i = 0; i < 10; i++) begin
      cyc(1, W'(16'h5000 + i), 1);
      check_state("R7");
    end
    while (model.size() > 0) begin
      cyc(0, '0, 1);
      check_state("R7");
    end
  endtask

  task automatic t_edges();
    cyc(1, 16'h6000, 1);
    check_state("R8");
    chk(empty == 1'b0, "R8", "empty both", empty, 0);
    for (int i = 1; i < DEPTH; i++) cyc(1, W'(16'h6000 + i), 0);
    check_state("R8");
    cyc(1, 16'h7777, 1);
    check_state("R8");
    chk(full == 1'b0, "R8", "full both", full, 0);
    while (model.size() > 0) begin
      cyc(0, '0, 1);
      check_state("R8");
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_show_ahead();
    t_order();
    t_fill();
    t_underflow();
    t_simul();
    t_edges();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule